// File: doc/BRIEF.md
# Priority Memory Protection Checker

This block decides, one access at a time, whether a memory request may proceed. Each request carries an address, a read/write flag, an instruction/data flag and a privilege flag. Eight programmable regions describe windows of the address space. Each region has its own base, size, permissions for instruction fetches and for data accesses, a 3-bit cache/buffer attribute and an enable. Regions may overlap. Where several enabled regions contain the address, the highest-numbered one decides. A low-numbered region spanning the whole space can therefore act as a privileged-only background, while a higher region is moved over whichever task is running.

The answer is registered. One cycle after a valid request the block raises a response with a permit bit and the winning region's attributes. A global control word switches checking on or off and carries two cache enables that the block passes straight out. Software programs everything through a single write port that selects a region, a word kind and a 32-bit value.

Top module: `region_guard`

## Requirements
- R1: While reset is asserted, every region is disabled, checking is off, `dCacheEn` and `iCacheEn` are 0 and `rspValid` is 0.
- R2: `rspValid` is 1 exactly in the cycle after a cycle with `accValid` high. Whenever `rspValid` is 0, `rspPermit` and `rspAttr` are 0.
- R3: When control bit 0 is 0, every access is answered with `rspPermit`=1 and `rspAttr`=000.
- R4: A control write (`cfgKind`=2) loads bit 0 as the check enable, bit 2 as `dCacheEn` and bit 12 as `iCacheEn`. These are visible the next cycle and hold until the next control write.
- R5: A geometry word (`cfgKind`=0) holds the base in bits [31:5] and a size code N in bits [4:0]. The region spans 2^(N+1) bytes, and only address bits [31:N+1] are compared with the base. Codes below 4 act as 4 (32 bytes), and code 31 covers the full 4 GB space.
- R6: When several enabled regions contain the address, the highest-numbered one supplies both the permit decision and `rspAttr`, whether the access is permitted or aborted.
- R7: With checking on, an access that lies in no enabled region is aborted with `rspAttr`=000.
- R8: Permission codes are 00 no access, 01 privileged only, 10 privileged any plus user read, and 11 everyone. An instruction fetch (`accInstr`=1) is judged by the instruction code and a data access by the data code. A user write to a code-10 region aborts.
- R9: A rights word (`cfgKind`=1) holds the instruction permission in [1:0], the data permission in [3:2], the attribute in [6:4] and the enable in [8]. Attribute bit 2 means instruction cacheable, bit 1 data cacheable and bit 0 bufferable. A write with `cfgKind`=3 changes nothing.
- R10: An access made in the same cycle as a configuration write is judged against the configuration that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Word kind: 0 geometry, 1 rights, 2 control, 3 unused |
| cfgRegion | input | 3 | Region addressed by geometry and rights writes |
| cfgWdata | input | 32 | Configuration value |
| accValid | input | 1 | Access request valid |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 = write, 0 = read |
| accInstr | input | 1 | 1 = instruction fetch, 0 = data access |
| accPriv | input | 1 | 1 = privileged, 0 = user |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspPermit | output | 1 | 1 = permitted, 0 = aborted |
| rspAttr | output | 3 | Attributes of the deciding region |
| dCacheEn | output | 1 | Data cache enable from the control word |
| iCacheEn | output | 1 | Instruction cache enable from the control word |

## Verification
A wrong stored base, size or enable appears as a wrong permit or attribute on the first response that touches the affected window. Wrong priority shows only where regions overlap, so the stimulus deliberately probes addresses covered by two or three regions at once. Control state is visible on the cache enable pins in the cycle after the write, and it is compared in every cycle. Each response is predicted one cycle ahead by a behavioural model and compared in the cycle it appears, so any fault surfaces within one clock of the access that exposes it.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int unsigned REGIONS      = 8;
  localparam int unsigned IDX_W        = $clog2(REGIONS);
  localparam int unsigned ADDR_W       = 32;
  localparam int unsigned SIZE_W       = 5;
  localparam int unsigned MIN_SIZE     = 4;
  localparam int unsigned BASE_LSB     = MIN_SIZE + 1;
  localparam int unsigned ATTR_W       = 3;
  localparam int unsigned CTRL_CHECK   = 0;
  localparam int unsigned CTRL_DCACHE  = 2;
  localparam int unsigned CTRL_ICACHE  = 12;
  localparam int unsigned RIGHTS_EN    = 8;

  typedef enum logic [1:0] {
    KIND_GEOM   = 2'd0,
    KIND_RIGHTS = 2'd1,
    KIND_CTRL   = 2'd2,
    KIND_NONE   = 2'd3
  } cfgKind_e;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'd0,
    PERM_PRIV  = 2'd1,
    PERM_UREAD = 2'd2,
    PERM_FULL  = 2'd3
  } perm_e;

  typedef struct packed {
    logic [REGIONS-1:0] geomWe;
    logic [REGIONS-1:0] rightsWe;
    logic               ctrlWe;
    logic               sample;
  } strobe_t;
endpackage

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
(
  input  logic             cfgWe,
  input  logic [1:0]       cfgKind,
  input  logic [IDX_W-1:0] cfgRegion,
  input  logic             accValid,
  output strobe_t          strb
);
  always_comb begin
    strb        = '0;
    strb.sample = accValid;
    if (cfgWe) begin
      case (cfgKind)
        KIND_GEOM:   strb.geomWe[cfgRegion]   = 1'b1;
        KIND_RIGHTS: strb.rightsWe[cfgRegion] = 1'b1;
        KIND_CTRL:   strb.ctrlWe              = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/prot_datapath.sv
module prot_datapath
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [31:0]       cfgWdata,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accInstr,
  input  logic              accPriv,
  output logic              rspValid,
  output logic              rspPermit,
  output logic [ATTR_W-1:0] rspAttr,
  output logic              checkEn,
  output logic              dCacheEn,
  output logic              iCacheEn
);
  localparam int unsigned SPAN_W = ADDR_W + 1;
  localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
  localparam logic [SPAN_W-1:0] SPAN_ONE = SPAN_W'(1);

  logic [REGIONS-1:0]             hitVec;
  logic [REGIONS-1:0]             allowVec;
  logic [REGIONS-1:0][ATTR_W-1:0] attrVec;

  for (genvar g = 0; g < REGIONS; g++) begin : gRegion
    logic [BASE_W-1:0] baseQ;
    logic [SIZE_W-1:0] sizeQ;
    logic [1:0]        iPermQ, dPermQ;
    logic [ATTR_W-1:0] attrQ;
    logic              enQ;
    logic [SIZE_W-1:0] effSize;
    logic [5:0]        shiftAmt;
    logic [SPAN_W-1:0] spanMask;
    logic [ADDR_W-1:0] cmpMask;
    logic [1:0]        perm;
    logic              hit, allow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        sizeQ <= '0;
      end else if (strb.geomWe[g]) begin
        baseQ <= cfgWdata[ADDR_W-1:BASE_LSB];
        sizeQ <= cfgWdata[SIZE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        iPermQ <= PERM_NONE;
        dPermQ <= PERM_NONE;
        attrQ  <= '0;
        enQ    <= 1'b0;
      end else if (strb.rightsWe[g]) begin
        iPermQ <= cfgWdata[1:0];
        dPermQ <= cfgWdata[3:2];
        attrQ  <= cfgWdata[6:4];
        enQ    <= cfgWdata[RIGHTS_EN];
      end
    end

    always_comb begin
      effSize  = (sizeQ < SIZE_W'(MIN_SIZE)) ? SIZE_W'(MIN_SIZE) : sizeQ;
      shiftAmt = {1'b0, effSize} + 6'd1;
      spanMask = (SPAN_ONE << shiftAmt) - SPAN_ONE;
      cmpMask  = ~spanMask[ADDR_W-1:0];
      hit      = enQ && (((accAddr ^ {baseQ, {BASE_LSB{1'b0}}}) & cmpMask) == '0);
      perm     = accInstr ? iPermQ : dPermQ;
      if (accPriv) allow = (perm != PERM_NONE);
      else         allow = (perm == PERM_FULL) || ((perm == PERM_UREAD) && !accWrite);
    end

    assign hitVec[g]   = hit;
    assign allowVec[g] = allow;
    assign attrVec[g]  = attrQ;
  end

  logic              winHit, winAllow;
  logic [ATTR_W-1:0] winAttr;

  always_comb begin
    winHit   = 1'b0;
    winAllow = 1'b0;
    winAttr  = '0;
    for (int k = 0; k < REGIONS; k++) begin
      if (hitVec[k]) begin
        winHit   = 1'b1;
        winAllow = allowVec[k];
        winAttr  = attrVec[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      checkEn  <= 1'b0;
      dCacheEn <= 1'b0;
      iCacheEn <= 1'b0;
    end else if (strb.ctrlWe) begin
      checkEn  <= cfgWdata[CTRL_CHECK];
      dCacheEn <= cfgWdata[CTRL_DCACHE];
      iCacheEn <= cfgWdata[CTRL_ICACHE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspPermit <= 1'b0;
      rspAttr   <= '0;
    end else begin
      rspValid <= strb.sample;
      if (!strb.sample) begin
        rspPermit <= 1'b0;
        rspAttr   <= '0;
      end else if (!checkEn) begin
        rspPermit <= 1'b1;
        rspAttr   <= '0;
      end else begin
        rspPermit <= winHit && winAllow;
        rspAttr   <= winHit ? winAttr : '0;
      end
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import prot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgKind,
  input  logic [2:0]  cfgRegion,
  input  logic [31:0] cfgWdata,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic        accWrite,
  input  logic        accInstr,
  input  logic        accPriv,
  output logic        rspValid,
  output logic        rspPermit,
  output logic [2:0]  rspAttr,
  output logic        dCacheEn,
  output logic        iCacheEn
);
  strobe_t strb;
  logic    checkEn;

  prot_ctrl u_ctrl (
    .cfgWe     (cfgWe),
    .cfgKind   (cfgKind),
    .cfgRegion (cfgRegion),
    .accValid  (accValid),
    .strb      (strb)
  );

  prot_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWdata  (cfgWdata),
    .accAddr   (accAddr),
    .accWrite  (accWrite),
    .accInstr  (accInstr),
    .accPriv   (accPriv),
    .rspValid  (rspValid),
    .rspPermit (rspPermit),
    .rspAttr   (rspAttr),
    .checkEn   (checkEn),
    .dCacheEn  (dCacheEn),
    .iCacheEn  (iCacheEn)
  );
endmodule

// File: rtl/region_guard_sva.sv
module region_guard_sva (
  input logic       clk,
  input logic       rstN,
  input logic       accValid,
  input logic       cfgWe,
  input logic [1:0] cfgKind,
  input logic [2:0] ctrlBits,
  input logic       rspValid,
  input logic       rspPermit,
  input logic [2:0] rspAttr,
  input logic       checkEn,
  input logic       dCacheEn,
  input logic       iCacheEn
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!rspValid && !rspPermit && rspAttr == 3'b000));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !checkEn) |=> (rspPermit && rspAttr == 3'b000));

  assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgKind == 2'd2) |=>
      (checkEn == $past(ctrlBits[0]) && dCacheEn == $past(ctrlBits[1]) &&
       iCacheEn == $past(ctrlBits[2])));

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && cfgKind == 2'd2) |=>
      ($stable(checkEn) && $stable(dCacheEn) && $stable(iCacheEn)));
endmodule

bind region_guard region_guard_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .cfgWe     (cfgWe),
  .cfgKind   (cfgKind),
  .ctrlBits  ({cfgWdata[12], cfgWdata[2], cfgWdata[0]}),
  .rspValid  (rspValid),
  .rspPermit (rspPermit),
  .rspAttr   (rspAttr),
  .checkEn   (checkEn),
  .dCacheEn  (dCacheEn),
  .iCacheEn  (iCacheEn)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgKind = 2'd0;
  logic [2:0]  cfgRegion = 3'd0;
  logic [31:0] cfgWdata = 32'd0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = 32'd0;
  logic        accWrite = 1'b0;
  logic        accInstr = 1'b0;
  logic        accPriv = 1'b0;
  logic        rspValid, rspPermit, dCacheEn, iCacheEn;
  logic [2:0]  rspAttr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string phaseTag = "R1";

  always #10 clk = ~clk;

  region_guard u_region_guard (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgRegion(cfgRegion), .cfgWdata(cfgWdata), .accValid(accValid),
    .accAddr(accAddr), .accWrite(accWrite), .accInstr(accInstr),
    .accPriv(accPriv), .rspValid(rspValid), .rspPermit(rspPermit),
    .rspAttr(rspAttr), .dCacheEn(dCacheEn), .iCacheEn(iCacheEn)
  );

  // behavioural reference model
  logic [31:0] mBase [8];
  int          mSize [8];
  logic [1:0]  mIp [8];
  logic [1:0]  mDp [8];
  logic [2:0]  mAttr [8];
  logic        mEn [8];
  logic        mCheck, mD, mI;
  logic        expValid, expPermit;
  logic [2:0]  expAttr;
  string       expTag = "R1";

  always @(posedge clk) begin
    int win, hits, n;
    longint unsigned span;
    logic [1:0] p;
    logic ok;
    if (!rstN) begin
      for (int r = 0; r < 8; r++) begin
        mBase[r] = 0; mSize[r] = 0; mIp[r] = 0; mDp[r] = 0; mAttr[r] = 0; mEn[r] = 0;
      end
      mCheck = 0; mD = 0; mI = 0;
      expValid = 0; expPermit = 0; expAttr = 0; expTag = "R1";
    end else begin
      expValid = accValid; expPermit = 0; expAttr = 0; expTag = "R2";
      if (accValid) begin
        if (!mCheck) begin
          expPermit = 1; expTag = "R3";
        end else begin
          win = -1; hits = 0;
          for (int r = 0; r < 8; r++) begin
            if (mEn[r]) begin
              n = (mSize[r] < 4) ? 4 : mSize[r];
              span = 64'd1 << (n + 1);
              if (({32'd0, accAddr} / span) == ({32'd0, mBase[r]} / span)) begin
                win = r; hits++;
              end
            end
          end
          if (win < 0) begin
            expTag = "R7";
          end else begin
            p = accInstr ? mIp[win] : mDp[win];
            if (accPriv) ok = (p != 2'd0);
            else         ok = (p == 2'd3) || (p == 2'd2 && !accWrite);
            expPermit = ok;
            expAttr = mAttr[win];
            expTag = (hits > 1) ? "R6" : "R8";
          end
        end
      end
      if (cfgWe) begin
        case (cfgKind)
          2'd0: begin mBase[cfgRegion] = cfgWdata & 32'hFFFF_FFE0; mSize[cfgRegion] = int'(cfgWdata[4:0]); end
          2'd1: begin
            mIp[cfgRegion] = cfgWdata[1:0]; mDp[cfgRegion] = cfgWdata[3:2];
            mAttr[cfgRegion] = cfgWdata[6:4]; mEn[cfgRegion] = cfgWdata[8];
          end
          2'd2: begin mCheck = cfgWdata[0]; mD = cfgWdata[2]; mI = cfgWdata[12]; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (rspValid !== expValid || rspPermit !== expPermit || rspAttr !== expAttr ||
          dCacheEn !== mD || iCacheEn !== mI) begin
        errors++;
        $display("FAIL %s/%s: valid=%0b permit=%0b attr=%03b dc=%0b ic=%0b expected valid=%0b permit=%0b attr=%03b dc=%0b ic=%0b",
                 phaseTag, expTag, rspValid, rspPermit, rspAttr, dCacheEn, iCacheEn,
                 expValid, expPermit, expAttr, mD, mI);
      end
    end
  end

  task automatic step(input logic we, input logic [1:0] kind, input logic [2:0] rg,
                      input logic [31:0] wd, input logic av, input logic [31:0] addr,
                      input logic wr, input logic ins, input logic priv);
    @(negedge clk);
    cfgWe = we; cfgKind = kind; cfgRegion = rg; cfgWdata = wd;
    accValid = av; accAddr = addr; accWrite = wr; accInstr = ins; accPriv = priv;
  endtask

  task automatic cfg(input logic [1:0] kind, input logic [2:0] rg, input logic [31:0] wd);
    step(1'b1, kind, rg, wd, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic acc(input logic [31:0] addr, input logic wr, input logic ins, input logic priv);
    step(1'b0, 2'd0, 3'd0, 32'd0, 1'b1, addr, wr, ins, priv);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [31:0] rights(input logic [1:0] ip, input logic [1:0] dp,
                                         input logic [2:0] at, input logic en);
    return {23'd0, en, 1'b0, at, dp, ip};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspPermit !== 1'b0 || rspAttr !== 3'b000 ||
        dCacheEn !== 1'b0 || iCacheEn !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b permit=%0b attr=%03b dc=%0b ic=%0b expected all 0",
               rspValid, rspPermit, rspAttr, dCacheEn, iCacheEn);
    end
    rstN = 1'b1;

    // R3 and R2: checking off, mixed flags, gaps between requests
    phaseTag = "R3";
    acc(32'h0000_0100, 1'b0, 1'b0, 1'b0);
    acc(32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0);
    idle();
    phaseTag = "R2";
    acc(32'h1234_5678, 1'b0, 1'b1, 1'b1);
    idle(); idle();

    // R9 and R5: program the regions, checking still off
    phaseTag = "R9";
    cfg(2'd0, 3'd0, 32'h0000_001F);                        // whole space
    cfg(2'd1, 3'd0, rights(2'd1, 2'd1, 3'b110, 1'b1));
    cfg(2'd0, 3'd1, 32'h0001_000F);                        // 64 KB shared
    cfg(2'd1, 3'd1, rights(2'd3, 2'd3, 3'b111, 1'b1));
    cfg(2'd0, 3'd2, 32'h0002_000E);                        // 32 KB task window
    cfg(2'd1, 3'd2, rights(2'd3, 2'd3, 3'b101, 1'b1));
    cfg(2'd0, 3'd3, 32'h1000_0014);                        // 2 MB devices
    cfg(2'd1, 3'd3, rights(2'd0, 2'd2, 3'b000, 1'b1));
    phaseTag = "R3";
    acc(32'h0000_0100, 1'b0, 1'b0, 1'b0);

    // R4: control word enables checking and both caches
    phaseTag = "R4";
    cfg(2'd2, 3'd0, 32'h0000_1005);
    idle();

    // R6 and R8: overlapping regions and permission codes
    phaseTag = "R6";
    acc(32'h0000_0100, 1'b0, 1'b0, 1'b0);   // background, user: abort, attr 110
    acc(32'h0000_0100, 1'b1, 1'b0, 1'b1);   // background, privileged: permit
    acc(32'h0001_0010, 1'b1, 1'b0, 1'b0);   // shared over background
    acc(32'h0002_0004, 1'b0, 1'b1, 1'b0);   // running task
    acc(32'h0002_8004, 1'b0, 1'b0, 1'b0);   // just past task window
    phaseTag = "R8";
    acc(32'h1000_0040, 1'b1, 1'b0, 1'b0);   // user write, read-only: abort
    acc(32'h1000_0040, 1'b0, 1'b0, 1'b0);   // user read: permit
    acc(32'h1000_0040, 1'b1, 1'b0, 1'b1);   // privileged write: permit
    acc(32'h1000_0000, 1'b0, 1'b1, 1'b1);   // fetch from no-execute: abort
    acc(32'h101F_FFFC, 1'b0, 1'b0, 1'b0);   // last word of 2 MB
    acc(32'h1020_0000, 1'b0, 1'b0, 1'b0);   // first word past it

    // R6: move the task window
    phaseTag = "R6";
    cfg(2'd0, 3'd2, 32'h0002_800E);
    acc(32'h0002_0004, 1'b0, 1'b0, 1'b0);
    acc(32'h0002_8004, 1'b0, 1'b0, 1'b0);

    // R5: small size codes and the full-space code
    phaseTag = "R5";
    cfg(2'd0, 3'd4, 32'h0000_0302);                        // code 2 acts as 4
    cfg(2'd1, 3'd4, rights(2'd3, 2'd3, 3'b001, 1'b1));
    acc(32'h0000_031C, 1'b0, 1'b0, 1'b0);
    acc(32'h0000_0320, 1'b0, 1'b0, 1'b0);
    acc(32'h0000_02FC, 1'b0, 1'b0, 1'b0);
    cfg(2'd0, 3'd5, 32'hFFFF_001F);                        // code 31, unaligned base
    cfg(2'd1, 3'd5, rights(2'd3, 2'd3, 3'b010, 1'b1));
    acc(32'h0500_0000, 1'b1, 1'b0, 1'b0);
    acc(32'h0000_031C, 1'b0, 1'b1, 1'b0);
    cfg(2'd1, 3'd5, rights(2'd3, 2'd3, 3'b010, 1'b0));

    // R7: no background, unmatched address aborts
    phaseTag = "R7";
    cfg(2'd1, 3'd0, rights(2'd1, 2'd1, 3'b110, 1'b0));
    acc(32'h0500_0000, 1'b0, 1'b0, 1'b1);
    acc(32'h0001_0010, 1'b0, 1'b0, 1'b0);

    // R10: access and config write in the same cycle
    phaseTag = "R10";
    step(1'b1, 2'd1, 3'd1, rights(2'd3, 2'd3, 3'b111, 1'b0),
         1'b1, 32'h0001_0010, 1'b0, 1'b0, 1'b0);
    acc(32'h0001_0010, 1'b0, 1'b0, 1'b0);

    // R9: kind 3 writes change nothing
    phaseTag = "R9";
    cfg(2'd3, 3'd1, 32'hFFFF_FFFF);
    cfg(2'd3, 3'd0, 32'h0000_0000);
    acc(32'h0001_0010, 1'b0, 1'b0, 1'b0);
    acc(32'h0002_8004, 1'b0, 1'b0, 1'b0);

    // R4 and R3: one cache only, then checking off again
    phaseTag = "R4";
    cfg(2'd2, 3'd0, 32'h0000_0005);
    acc(32'h0500_0000, 1'b0, 1'b0, 1'b0);
    cfg(2'd2, 3'd0, 32'h0000_1000);
    phaseTag = "R3";
    acc(32'h0500_0000, 1'b1, 1'b1, 1'b0);
    acc(32'h1000_0000, 1'b1, 1'b0, 1'b0);
    idle(); idle();

    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule